// File: doc/BRIEF.md
# Sixteen-bit timer and event counter

This block holds a 16-bit up-counter that software sees as two byte registers, one for each half of the count. A control register picks what advances the count: in timer mode it steps on every cycle in which the instruction-cycle enable pulse is high. In counter mode it steps on rising edges of an external clock input. Counter mode comes in two flavours. The synchronous one passes the external clock through a two-stage synchronizer and waits for the next enable pulse. The asynchronous one steps on the edge itself, without waiting for the enable.

When the count wraps from 0xFFFF to 0x0000, a sticky overflow flag is set, and an interrupt line is raised while both the flag and its enable bit are set. A compare unit elsewhere in the chip can pulse a trigger input that clears the count at once, whatever software is doing. Everything runs in one system clock domain. The external clock is sampled there, and the asynchronous flavour is modelled as edge detection with a single sampling flop.

Top module: `tmr16_core`

## Requirements
- R1: After reset, both count bytes, the control register, the overflow flag, the interrupt enable and the irq output are all zero.
- R2: Register map on the 2-bit address: 0 is the count low byte, 1 is the count high byte, 2 is control (bit0 run, bit1 source select with 1 = external clock, bit2 counter flavour with 1 = asynchronous), and 3 is interrupt (bit0 overflow flag, bit1 interrupt enable). Every register reads back what was written, and unused bits read 0. A write takes effect at the next clock edge, and rd_data follows the address combinationally.
- R3: An increment from 0xFFFF sets the overflow flag. The flag stays set until software writes address 3 with bit0 = 0. If an overflow happens in the same cycle as that clearing write, the flag stays set.
- R4: irq is high exactly when the overflow flag and the interrupt enable are both 1.
- R5: In timer mode (bit1 = 0) with run set, the count rises by one at each clock edge at which cyc_en is high.
- R6: With run clear, the count holds its value whatever cyc_en and ext_clk do.
- R7: A high evt_clr at a clock edge leaves the count at 0x0000, and it wins over a byte write and over an increment in the same cycle.
- R8: In synchronous counter mode, a rising edge of ext_clk first sampled at edge k is counted once, at the first edge k+2 or later at which cyc_en is high.
- R9: In asynchronous counter mode, a rising edge of ext_clk first sampled at edge k is counted at edge k, whatever the value of cyc_en.
- R10: A write to either count byte cancels the whole increment of that cycle; the other byte keeps its value.
- R11: The carry from the low byte into the high byte happens at the same edge at which the low byte wraps from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable pulse |
| ext_clk | input | 1 | External count clock, sampled on clk |
| evt_clr | input | 1 | Special event clear from the compare unit |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that evt_clr and reg_wr are the only inputs that can change the count outside of an increment. They also assume the bus never writes two registers in one cycle, which this interface cannot express anyway. The stimulus drives every input in the middle of the low clock phase, so the external clock is already a clean sample at each edge. It also holds ext_clk steady for several cycles in synchronous mode, so that no edge is lost inside the synchronizer while a count is still pending.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    RA_CNT_LO = 2'd0,
    RA_CNT_HI = 2'd1,
    RA_CTRL   = 2'd2,
    RA_INT    = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic async_sel;
    logic ext_sel;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr16_tick_gen.sv
module tmr16_tick_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ext_sel,
  input  logic async_sel,
  input  logic cyc_en,
  input  logic ext_clk,
  output logic tick
);
  logic [SYNC_STAGES:0] sh_q;
  logic                 ext_last_q;
  logic                 pend_q;
  logic                 rise_sync, rise_async, sync_mode, sync_tick;

  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= ext_clk;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= sh_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ext_last_q <= 1'b0;
    else        ext_last_q <= ext_clk;

  assign rise_sync  = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign rise_async = ext_clk & ~ext_last_q;
  assign sync_mode  = run & ext_sel & ~async_sel;
  assign sync_tick  = sync_mode & (pend_q | rise_sync) & cyc_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= sync_mode & (pend_q | rise_sync) & ~cyc_en;

  always_comb begin
    if (!run)          tick = 1'b0;
    else if (!ext_sel) tick = cyc_en;
    else if (async_sel) tick = rise_async;
    else               tick = sync_tick;
  end

  AST_SYNC_WAITS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ext_sel && !async_sel) |-> cyc_en); // R8
  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick); // R6
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic [CNT_W/BYTE_W-1:0]     wr_byte,
  input  logic [BYTE_W-1:0]           wdata,
  input  logic                        inc,
  output logic [CNT_W-1:0]            count,
  output logic                        ovf
);
  localparam int NB = CNT_W / BYTE_W;

  logic [NB:0] carry;
  assign carry[0] = inc & ~(|wr_byte) & ~clr;

  genvar i;
  generate
    for (i = 0; i < NB; i++) begin : g_byte
      assign carry[i+1] = carry[i] & (&count[i*BYTE_W +: BYTE_W]);
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)          count[i*BYTE_W +: BYTE_W] <= '0;
        else if (clr)        count[i*BYTE_W +: BYTE_W] <= '0;
        else if (wr_byte[i]) count[i*BYTE_W +: BYTE_W] <= wdata;
        else if (carry[i])   count[i*BYTE_W +: BYTE_W] <= count[i*BYTE_W +: BYTE_W] + 1'b1;
    end
  endgenerate

  assign ovf = carry[NB];

  AST_EVT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr && wr_byte == '0) |=> $stable(count)); // R6
  AST_LOW_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && wr_byte == '0 && count[BYTE_W-1:0] == '1)
      |=> (count[BYTE_W-1:0] == '0 && count[2*BYTE_W-1:BYTE_W] == $past(count[2*BYTE_W-1:BYTE_W]) + 1'b1)); // R11
  AST_WRITE_BEATS_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && wr_byte[0]) |=> (count[BYTE_W-1:0] == $past(wdata))); // R10
endmodule

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_int,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ovf,
  output ctrl_t             ctrl,
  output logic              flag,
  output logic              ie
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl <= '0;
    else if (wr_ctrl) ctrl <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag <= 1'b0;
      ie   <= 1'b0;
    end else begin
      flag <= ovf | (wr_int ? wdata[0] : flag);
      if (wr_int) ie <= wdata[1];
    end

  AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_int && !wdata[0])) |=> flag); // R3
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              ext_clk,
  input  logic              evt_clr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int NB    = CNT_W / DATA_W;

  ctrl_t             ctrl;
  logic              flag, ie, tick, ovf;
  logic [CNT_W-1:0]  count;
  logic [NB-1:0]     wr_byte;
  logic              wr_ctrl, wr_int;

  assign wr_byte[0] = reg_wr && (reg_addr == RA_CNT_LO);
  assign wr_byte[1] = reg_wr && (reg_addr == RA_CNT_HI);
  assign wr_ctrl    = reg_wr && (reg_addr == RA_CTRL);
  assign wr_int     = reg_wr && (reg_addr == RA_INT);

  tmr16_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .ext_sel(ctrl.ext_sel),
    .async_sel(ctrl.async_sel), .cyc_en(cyc_en), .ext_clk(ext_clk), .tick(tick)
  );

  tmr16_counter #(.CNT_W(CNT_W), .BYTE_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(evt_clr), .wr_byte(wr_byte),
    .wdata(reg_wdata), .inc(tick), .count(count), .ovf(ovf)
  );

  tmr16_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_int(wr_int),
    .wdata(reg_wdata), .ovf(ovf), .ctrl(ctrl), .flag(flag), .ie(ie)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CNT_LO: reg_rdata = count[DATA_W-1:0];
      RA_CNT_HI: reg_rdata = count[CNT_W-1:DATA_W];
      RA_CTRL:   reg_rdata[$bits(ctrl_t)-1:0] = ctrl;
      default:   reg_rdata[1:0] = {ie, flag};
    endcase
  end

  assign irq = flag & ie;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_int && !reg_wdata[1]) |=> !irq); // R4
endmodule

// File: tb/sim_tmr16_core.sv
module sim_tmr16_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0, ext_clk = 1'b0, evt_clr = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq;

  always #10 clk = ~clk;

  tmr16_core u0 (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_clk(ext_clk), .evt_clr(evt_clr),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // reference state
  int m_cnt, m_run, m_ext, m_asy, m_flag, m_ie, m_pend, h1, h2, h3;
  int rs, ra, tk, cwr, ovf, exp_rd;

  function automatic int model_read(int a);
    case (a)
      0: return m_cnt & 255;
      1: return (m_cnt >> 8) & 255;
      2: return m_run | (m_ext << 1) | (m_asy << 2);
      default: return m_flag | (m_ie << 1);
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_ext = 0; m_asy = 0; m_flag = 0; m_ie = 0;
      m_pend = 0; h1 = 0; h2 = 0; h3 = 0;
    end else begin
      rs  = (h2 != 0 && h3 == 0);
      ra  = (ext_clk && h1 == 0);
      tk  = 0;
      if (m_run != 0) begin
        if (m_ext == 0) tk = cyc_en;
        else if (m_asy != 0) tk = ra;
        else tk = (m_pend != 0 || rs) && cyc_en;
      end
      m_pend = (m_run != 0 && m_ext != 0 && m_asy == 0 && (m_pend != 0 || rs) && !cyc_en);
      cwr = reg_wr && reg_addr < 2;
      ovf = tk && !cwr && !evt_clr && m_cnt == 65535;
      if (evt_clr) m_cnt = 0;
      else if (cwr) begin
        if (reg_addr == 0) m_cnt = (m_cnt & 16'hFF00) | reg_wdata;
        else m_cnt = (m_cnt & 16'h00FF) | (reg_wdata << 8);
      end else if (tk != 0) m_cnt = (m_cnt + 1) & 16'hFFFF;
      if (reg_wr && reg_addr == 2) begin
        m_run = reg_wdata[0]; m_ext = reg_wdata[1]; m_asy = reg_wdata[2];
      end
      if (reg_wr && reg_addr == 3) begin
        m_flag = reg_wdata[0]; m_ie = reg_wdata[1];
      end
      if (ovf != 0) m_flag = 1;
      h3 = h2; h2 = h1; h1 = ext_clk;
    end
    #2;
    if (!done) begin
      exp_rd = model_read(reg_addr);
      check(tag, reg_rdata, exp_rd);
      check("R4", irq, m_flag & m_ie);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_wr = 0;
      reg_addr = 2'(i);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 2'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic peek(int a);
    @(negedge clk);
    reg_wr = 0; reg_addr = 2'(a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; idle(4);
    // register map
    tag = "R2";
    wr(0, 8'h34); wr(1, 8'h12); peek(0); peek(1);
    wr(2, 8'hFA); peek(2); wr(2, 0); wr(3, 8'hFE); peek(3); wr(3, 0); peek(3);
    // timer mode with varying enable
    tag = "R5";
    wr(0, 0); wr(1, 0); wr(2, 1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); cyc_en = (i % 3 != 1); reg_addr = 2'(i % 2);
    end
    // low byte carry
    tag = "R11";
    wr(2, 0); wr(0, 8'hFD); wr(1, 8'h07); wr(2, 1);
    cyc_en = 1; idle(8);
    // stopped hold
    tag = "R6";
    wr(2, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); cyc_en = i[0]; ext_clk = i[1]; reg_addr = 2'(i % 2);
    end
    ext_clk = 0;
    // overflow, sticky flag, enable
    tag = "R3";
    cyc_en = 1; wr(0, 8'hFD); wr(1, 8'hFF); wr(2, 1); idle(6); peek(3); idle(3);
    wr(3, 2); peek(3);
    wr(3, 0); peek(3);
    // clear in same cycle as overflow
    wr(2, 0); wr(0, 8'hFF); wr(1, 8'hFF);
    @(negedge clk); reg_wr = 1; reg_addr = 2; reg_wdata = 1;
    @(negedge clk); reg_wr = 1; reg_addr = 3; reg_wdata = 2;
    @(negedge clk); reg_wr = 0; reg_addr = 3;
    idle(2);
    // event clear, also against a write
    tag = "R7";
    wr(3, 0); idle(4);
    @(negedge clk); evt_clr = 1; reg_addr = 0;
    @(negedge clk); evt_clr = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 8'h55;
    @(negedge clk); evt_clr = 0; reg_wr = 0; reg_addr = 0;
    idle(4);
    // write beats increment
    tag = "R10";
    wr(1, 8'h3C); peek(0); wr(0, 8'hFF); peek(1); idle(4);
    // synchronous counter with sparse enable
    tag = "R8";
    wr(2, 0); wr(0, 0); wr(1, 0); wr(2, 3);
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      ext_clk = ((i / 5) % 2 == 1);
      cyc_en = (i % 4 == 0);
      reg_addr = 2'(i % 2);
    end
    // asynchronous counter, enable held low
    tag = "R9";
    wr(2, 0); wr(0, 8'hF0); wr(2, 7);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      ext_clk = ((i / 3) % 2 == 1);
      cyc_en = 0;
      reg_addr = 2'(i % 2);
    end
    // async wrap across bytes
    tag = "R3";
    wr(2, 0); wr(0, 8'hFE); wr(1, 8'hFF); wr(3, 2); wr(2, 7);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); ext_clk = i[0]; reg_addr = 2'(3 - (i % 2) * 3);
    end
    idle(4);
    done = 1;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule